// File: doc/BRIEF.md
# Byte-Splittable General Register File

This block is the architectural register store of a 16-bit processor core. It holds fourteen 16-bit registers: four data registers, two pointer registers (stack and frame base), two index registers (source and destination), four segment registers (code, data, stack, extra), the instruction pointer and the flag word. Each data register is also reachable as two independent 8-bit halves.

A single write port takes a register code, a size select and a data word. A word write replaces one whole register. A byte write changes exactly one half of one data register and keeps the other half. Any number of read ports, two by default, each pick a register and a size. Their results come straight from the stored state with no clock in between. A byte read returns the chosen half zero-extended to 16 bits.

Top module: `gpr_file`

## Requirements
- R1: While reset is low, and after it is released with no write yet, every register reads back as zero.
- R2: With wr_en high and wr_byte low, the register with word code wr_sel takes wr_data at the clock edge. The word codes are: 0 to 3 for data registers 0 to 3, 4 for stack pointer, 5 for frame base, 6 for source index, 7 for destination index, 8 for code segment, 9 for data segment, 10 for stack segment, 11 for extra segment, 12 for instruction pointer, 13 for flags.
- R3: With wr_en and wr_byte high, byte code k in 0 to 3 writes wr_data[7:0] into the low half of data register k. Byte code k in 4 to 7 writes wr_data[7:0] into the high half of data register k-4. wr_data[15:8] is not used.
- R4: A byte write leaves the other half of the same data register unchanged.
- R5: A read with its byte select high returns the half chosen by the byte code (same mapping as R3) in bits 7:0, with bits 15:8 zero.
- R6: A read of the register being written in the same cycle returns the value held before the edge. The new value is visible from the next cycle.
- R7: With wr_en low, no register changes, whatever the other write inputs are.
- R8: Word codes 14 and 15 and byte codes 8 to 15 select nothing. A write with such a code changes no register, and a read with such a code returns zero.
- R9: Each read port selects independently and returns its own register in the same cycle.
- R10: A write changes only the register (or half) it selects. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, clears all registers |
| wr_en | input | 1 | Write enable |
| wr_byte | input | 1 | Write size: 1 = byte code, 0 = word code |
| wr_sel | input | 4 | Write register code |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| rd_byte | input | N_RD (2) | Per read port size: 1 = byte code, 0 = word code |
| rd_sel | input | N_RD x 4 | Per read port register code |
| rd_data | output | N_RD x 16 | Per read port result, combinational |

## Verification
The bench builds the block with its defaults: four data registers and two read ports. That gives a 4-bit code, so word codes 14 and 15 and byte codes 8 to 15 are unused encodings that uniformly random codes hit often. Random traffic frequently lands a read on the register being written, which exercises the old-value rule. It also often mixes byte and word writes on the same data register, which exercises the lane merge. With two ports, both ports can select the same register or different registers in one cycle.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Result of a write into a stored word: the whole word, or one lane from wdata's low byte.
  function automatic word_t merge_lanes(word_t old_w, word_t wdata, logic byte_mode, logic hi);
    word_t res;
    if (!byte_mode)
      res = wdata;
    else if (hi)
      res = {wdata[BYTE_W-1:0], old_w[BYTE_W-1:0]};
    else
      res = {old_w[WORD_W-1:BYTE_W], wdata[BYTE_W-1:0]};
    return res;
  endfunction

  // One half of a word, zero-extended to full width.
  function automatic word_t pick_half(word_t w, logic hi);
    byte_t b;
    b = hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    return {{(WORD_W-BYTE_W){1'b0}}, b};
  endfunction
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int N_DATA = 4,
  parameter int N_REG  = 14,
  parameter int SEL_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_byte,
  input  logic [SEL_W-1:0] wr_sel,
  output logic [N_REG-1:0] hit,
  output logic             hi_half
);
  logic             byte_ok;
  logic [SEL_W-1:0] byte_idx;

  assign hi_half  = wr_sel >= SEL_W'(N_DATA);
  assign byte_ok  = wr_sel <  SEL_W'(2 * N_DATA);
  assign byte_idx = hi_half ? wr_sel - SEL_W'(N_DATA) : wr_sel;

  for (genvar i = 0; i < N_REG; i++) begin : g_hit
    if (i < N_DATA) begin : g_split
      assign hit[i] = wr_en && (wr_byte ? (byte_ok && byte_idx == SEL_W'(i))
                                        : (wr_sel == SEL_W'(i)));
    end else begin : g_whole
      assign hit[i] = wr_en && !wr_byte && (wr_sel == SEL_W'(i));
    end
  end

  // R10: one write touches at most one register
  assert_single_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  // R7: no target without the write enable
  assert_no_hit_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> hit == '0);
endmodule

// File: rtl/gpr_rd_mux.sv
module gpr_rd_mux
  import gpr_pkg::*;
#(
  parameter int N_DATA = 4,
  parameter int N_REG  = 14,
  parameter int SEL_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_REG-1:0][WORD_W-1:0]  regs_flat,
  input  logic                          rd_byte,
  input  logic [SEL_W-1:0]              rd_sel,
  output logic [WORD_W-1:0]             rd_data
);
  logic sel_valid;

  assign sel_valid = rd_byte ? (rd_sel < SEL_W'(2 * N_DATA)) : (rd_sel < SEL_W'(N_REG));

  always_comb begin
    rd_data = '0;
    if (sel_valid) begin
      if (!rd_byte)
        rd_data = regs_flat[rd_sel];
      else if (rd_sel >= SEL_W'(N_DATA))
        rd_data = pick_half(regs_flat[rd_sel - SEL_W'(N_DATA)], 1'b1);
      else
        rd_data = pick_half(regs_flat[rd_sel], 1'b0);
    end
  end

  // R5: byte reads carry zeros above the low byte
  assert_byte_read_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_byte |-> rd_data[WORD_W-1:BYTE_W] == '0);
  // R8: unused codes read as zero
  assert_bad_code_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> rd_data == '0);
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int N_DATA = 4,
  parameter int N_RD   = 2,
  localparam int N_PTR = 2,
  localparam int N_IDX = 2,
  localparam int N_SEG = 4,
  localparam int N_REG = N_DATA + N_PTR + N_IDX + N_SEG + 2,
  localparam int SEL_W = $clog2(N_REG)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        wr_byte,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic [N_RD-1:0]             rd_byte,
  input  logic [N_RD-1:0][SEL_W-1:0]  rd_sel,
  output logic [N_RD-1:0][WORD_W-1:0] rd_data
);
  word_t                       regs [N_REG];
  logic [N_REG-1:0][WORD_W-1:0] regs_flat;
  logic [N_REG-1:0]            hit;
  logic                        hi_half;
  logic [N_REG-1:0]            lo_only;
  logic [N_REG-1:0]            hi_only;
  logic                        bad_word_wr;

  gpr_wr_decode #(.N_DATA(N_DATA), .N_REG(N_REG), .SEL_W(SEL_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
    .wr_sel(wr_sel), .hit(hit), .hi_half(hi_half)
  );

  assign bad_word_wr = wr_en && !wr_byte && (wr_sel >= SEL_W'(N_REG));

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (hit[i])
        regs[i] <= merge_lanes(regs[i], wr_data, wr_byte, hi_half);
    end
    assign regs_flat[i] = regs[i];
    assign lo_only[i]   = hit[i] && wr_byte && !hi_half;
    assign hi_only[i]   = hit[i] && wr_byte && hi_half;

    // R7: idle write port holds every register
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs[i]));
    // R2: word write lands whole
    assert_word_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_byte && wr_sel == SEL_W'(i)) |=> regs[i] == $past(wr_data));
    // R8: unused word codes change nothing
    assert_bad_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bad_word_wr |=> $stable(regs[i]));

    if (i < N_DATA) begin : g_split_chk
      // R4: the untouched half keeps its value
      assert_lo_keeps_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_only[i] |=> regs[i][WORD_W-1:BYTE_W] == $past(regs[i][WORD_W-1:BYTE_W]));
      assert_hi_keeps_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hi_only[i] |=> regs[i][BYTE_W-1:0] == $past(regs[i][BYTE_W-1:0]));
      // R3: high-half byte code stores the low data byte
      assert_hi_byte_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte && wr_sel == SEL_W'(i + N_DATA))
          |=> regs[i][WORD_W-1:BYTE_W] == $past(wr_data[BYTE_W-1:0]));
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    gpr_rd_mux #(.N_DATA(N_DATA), .N_REG(N_REG), .SEL_W(SEL_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .regs_flat(regs_flat),
      .rd_byte(rd_byte[p]), .rd_sel(rd_sel[p]), .rd_data(rd_data[p])
    );
  end
endmodule

// File: tb/gpr_file_tb_top.sv
`timescale 1ns/1ps
module gpr_file_tb_top;
  localparam int NREG = 14;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en, wr_byte;
  logic [3:0]       wr_sel;
  logic [15:0]      wr_data;
  logic [1:0]       rd_byte;
  logic [1:0][3:0]  rd_sel;
  logic [1:0][15:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [15:0] m [NREG];

  always #2.5 clk = ~clk;

  gpr_file dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_byte(rd_byte),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  function automatic logic [15:0] exp_rd(int sel, bit b);
    if (b) begin
      if (sel >= 8) return 16'h0;
      if (sel >= 4) return {8'h00, m[sel-4][15:8]};
      return {8'h00, m[sel][7:0]};
    end
    if (sel >= NREG) return 16'h0;
    return m[sel];
  endfunction

  function automatic void model_write(bit we, bit b, int sel, logic [15:0] d);
    if (!we) return;
    if (b) begin
      if (sel < 4)      m[sel][7:0]    = d[7:0];
      else if (sel < 8) m[sel-4][15:8] = d[7:0];
    end else if (sel < NREG) begin
      m[sel] = d;
    end
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check reads before the edge (old state), then model the edge.
  task automatic step(bit we, bit wb, int ws, logic [15:0] wd,
                      bit b0, int s0, bit b1, int s1, string tag);
    @(negedge clk);
    wr_en = we; wr_byte = wb; wr_sel = 4'(ws); wr_data = wd;
    rd_byte = {b1, b0}; rd_sel[0] = 4'(s0); rd_sel[1] = 4'(s1);
    #1;
    chk(tag, rd_data[0], exp_rd(s0, b0));
    chk(tag, rd_data[1], exp_rd(s1, b1));
    model_write(we, wb, ws, wd);
  endtask

  task automatic sweep(string tag);
    for (int k = 0; k < 16; k += 2) step(0, 0, 0, 16'h0, 0, k, 0, k + 1, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NREG; k++) m[k] = 16'h0;
    rst_n = 0; wr_en = 0; wr_byte = 0; wr_sel = 0; wr_data = 0;
    rd_byte = 0; rd_sel = '0;
    #1;
    chk("R1 in reset", rd_data[0], 16'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    sweep("R1");

    // R2: word writes to every code, then a full readback (R10 isolation)
    for (int k = 0; k < NREG; k++) step(1, 0, k, 16'h1000 + 16'(k * 16'h0111), 0, k, 1, 7, "R2");
    sweep("R10");

    // R3/R4: byte writes with junk in wr_data[15:8]
    step(1, 1, 5, 16'hFFA5, 0, 1, 1, 5, "R3");
    step(0, 0, 0, 16'h0, 0, 1, 1, 5, "R4");
    step(1, 1, 2, 16'h773C, 0, 2, 1, 6, "R3");
    step(0, 0, 0, 16'h0, 0, 2, 1, 2, "R4");
    chk("R4 direct", m[1], 16'hA5 << 8 | 16'h0011 + 16'h1000 & 16'h00FF);
    sweep("R10");

    // R5: byte reads of all halves
    for (int k = 0; k < 8; k++) step(0, 0, 0, 16'h0, 1, k, 1, 7 - k, "R5");

    // R6: read the register being written
    step(1, 0, 9, 16'hBEEF, 0, 9, 0, 9, "R6");
    step(0, 0, 0, 16'h0, 0, 9, 1, 0, "R6");
    step(1, 1, 4, 16'h00C3, 1, 4, 0, 0, "R6");
    step(0, 0, 0, 16'h0, 1, 4, 0, 0, "R6");

    // R7: disabled write port
    for (int k = 0; k < 16; k++) step(0, k[0], k, 16'hDEAD, 0, k, 1, k & 7, "R7");
    sweep("R7");

    // R8: unused codes
    step(1, 0, 14, 16'h1234, 0, 14, 0, 15, "R8");
    step(1, 0, 15, 16'h5678, 1, 8,  1, 15, "R8");
    step(1, 1, 9,  16'h9ABC, 1, 12, 0, 14, "R8");
    sweep("R8");

    // R9: ports picking different registers and sizes
    step(0, 0, 0, 16'h0, 0, 12, 1, 3, "R9");
    step(0, 0, 0, 16'h0, 1, 6,  0, 13, "R9");

    // Constrained random traffic, fixed seed
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      bit we = ($urandom % 4) != 0;
      bit wb = $urandom % 2;
      int ws = $urandom % 16;
      logic [15:0] wd = 16'($urandom);
      bit b0 = $urandom % 2;
      int s0 = (($urandom % 3) == 0) ? ws : int'($urandom % 16);
      string tg;
      if (b0) tg = "R5";
      else if (we && s0 == ws && !wb) tg = "R6";
      else if (s0 >= NREG) tg = "R8";
      else tg = "R2";
      step(we, wb, ws, wd, b0, s0, $urandom % 2, $urandom % 16, tg);
    end
    sweep("R10");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule